// File: doc/BRIEF.md
# Program Memory Byte Reader

This block fetches one byte from a program memory that is organised as 16-bit words, while the address it is given is a byte address taken from the Z pointer pair. A single-cycle start pulse hands it the pointer value, the index of the destination register and two mode flags. One flag forces the destination to register 0. The other asks for the pointer to be advanced after the read.

The block turns the byte address into a word address by dropping the lane bit. It issues one synchronous word read and picks the byte lane that pointer bit 0 names: an even address gives the low half of the word and an odd address gives the high half. Three cycles after the start pulse is taken, it presents the byte, the destination index and a one-cycle write strobe for the register file. When the advance mode is requested, it also presents the pointer plus one, with its own strobe in that same cycle. Status flags are neither read nor written.

The memory array, the register file and instruction decode sit outside the block. The word memory must return data one cycle after the read request.

Top module: `pmem_byte_reader`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `mem_rd_o`, `rf_we_o` and `z_we_o` are all low.
- R2: In the first cycle after a start is accepted, `mem_rd_o` is high for exactly that one cycle and `mem_addr_o` equals the pointer shifted right by one bit.
- R3: The returned byte is bits [7:0] of the memory word when pointer bit 0 is 0, and bits [15:8] when it is 1. For example, word 0x5876 gives 0x76 at the even address and 0x58 at the odd address.
- R4: When `imp_r0_i` is 1, `rf_idx_o` is 0 whatever `dst_i` holds. When it is 0, `rf_idx_o` equals `dst_i`, with any value from 0 to 31.
- R5: When `post_inc_i` is 1, `z_we_o` pulses in the same cycle as `rf_we_o` and `z_o` equals the pointer plus one. When it is 0, `z_we_o` stays low.
- R6: Advancing a pointer of 0xFFFF gives 0x0000.
- R7: `rf_we_o` is a single-cycle pulse in the third cycle after the clock edge that accepts the start, so the operation takes three cycles.
- R8: `busy_o` is high for exactly the three cycles from the accepting edge up to and including the strobe cycle, and is low again in the cycle after the strobe.
- R9: A start pulse seen while `busy_o` is high is ignored. It launches no memory read and causes no further strobe.
- R10: The pointer, destination and mode inputs are sampled only at the accepting edge. Changing them later does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| z_i | input | 16 | Byte address (pointer pair) |
| dst_i | input | 5 | Destination register index |
| post_inc_i | input | 1 | Advance the pointer after the read |
| imp_r0_i | input | 1 | Force destination register 0 |
| mem_rd_o | output | 1 | Word read request |
| mem_addr_o | output | 15 | Word address |
| mem_rdata_i | input | 16 | Word data, valid one cycle after the request |
| busy_o | output | 1 | Operation in progress |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | 5 | Register index being written |
| rf_data_o | output | 8 | Byte being written |
| z_we_o | output | 1 | Pointer write strobe |
| z_o | output | 16 | Advanced pointer, valid with `z_we_o` |

## Verification
Two events can fall in the same cycle. The first is the register write strobe coinciding with a fresh start pulse, which must be dropped because the block is still busy. The second is the pointer strobe coinciding with the register strobe. The bench drives a start pulse in both the wait cycle and the strobe cycle of every operation. It then judges, in the following idle cycle, that no read was launched and no second strobe appeared. On every post-increment operation it also checks that both strobes and the advanced pointer appear together in the strobe cycle.

// File: rtl/pmr_pkg.sv
// Shared definitions for the program memory byte reader.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package pmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WBACK = 2'd3
    } pmr_state_e;
endpackage

// File: rtl/pmr_ctrl.sv
// Sequencer: idle -> read -> wait -> write-back -> idle.
// Assumes: start is honoured only in idle; the memory answers one cycle
// after the read request.
module pmr_ctrl
    import pmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic launch_o,
    output logic capture_o,
    output logic read_o,
    output logic wback_o,
    output logic busy_o
);
    pmr_state_e state_q, state_d;

    // Next-state selection; a start outside idle falls through unused.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_WBACK;
            ST_WBACK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded controls for the datapath and the ports.
    always_comb begin
        launch_o  = (state_q == ST_IDLE) && start_i;
        read_o    = (state_q == ST_READ);
        capture_o = (state_q == ST_WAIT);
        wback_o   = (state_q == ST_WBACK);
        busy_o    = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/pmr_lane_sel.sv
// Byte lane selector: splits a memory word into lanes and returns the
// lane named by the low address bits; lane 0 is the least significant.
// Assumes: WORD_W is a multiple of BYTE_W with at least two lanes.
module pmr_lane_sel #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // Pick the addressed lane.
    always_comb byte_o = lanes[lane_i];
endmodule

// File: rtl/pmr_z_update.sv
// Pointer advance: adds one modulo 2**Z_W, so the top value wraps to zero.
// Assumes: the caller decides whether the result is written back.
module pmr_z_update #(
    parameter int Z_W = 16
) (
    input  logic [Z_W-1:0] z_i,
    output logic [Z_W-1:0] z_next_o
);
    // Modular increment; the carry out is dropped on purpose.
    always_comb z_next_o = z_i + Z_W'(1);
endmodule

// File: rtl/pmem_byte_reader.sv
// Top: reads one byte from word-organised program memory using a byte
// pointer; optionally returns the advanced pointer.
// Assumes: synchronous memory with one cycle of read latency; z_o is
// meaningful only while z_we_o is high.
module pmem_byte_reader #(
    parameter int Z_W    = 16,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    localparam int LANE_W = $clog2(WORD_W / BYTE_W),
    localparam int ADDR_W = Z_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [Z_W-1:0]    z_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic              post_inc_i,
    input  logic              imp_r0_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [BYTE_W-1:0] rf_data_o,
    output logic              z_we_o,
    output logic [Z_W-1:0]    z_o
);
    logic              launch, capture, read_st, wback;
    logic [Z_W-1:0]    z_q;
    logic [IDX_W-1:0]  idx_q;
    logic              inc_q;
    logic [BYTE_W-1:0] byte_q, byte_sel;
    logic [Z_W-1:0]    z_next;

    pmr_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .launch_o  (launch),
        .capture_o (capture),
        .read_o    (read_st),
        .wback_o   (wback),
        .busy_o    (busy_o)
    );

    pmr_lane_sel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) lane_i (
        .word_i (mem_rdata_i),
        .lane_i (z_q[LANE_W-1:0]),
        .byte_o (byte_sel)
    );

    pmr_z_update #(.Z_W(Z_W)) zinc_i (
        .z_i      (z_q),
        .z_next_o (z_next)
    );

    // Operand capture at the accepting edge; implied form forces index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q   <= '0;
            idx_q <= '0;
            inc_q <= 1'b0;
        end else if (launch) begin
            z_q   <= z_i;
            idx_q <= imp_r0_i ? '0 : dst_i;
            inc_q <= post_inc_i;
        end
    end

    // Byte capture in the cycle the memory word is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)       byte_q <= '0;
        else if (capture) byte_q <= byte_sel;
    end

    // Port drive.
    always_comb begin
        mem_rd_o   = read_st;
        mem_addr_o = z_q[Z_W-1:LANE_W];
        rf_we_o    = wback;
        rf_idx_o   = idx_q;
        rf_data_o  = byte_q;
        z_we_o     = wback && inc_q;
        z_o        = z_next;
    end
endmodule

// File: rtl/pmr_checker.sv
// Protocol checker for pmem_byte_reader, attached by bind.
// Assumes: the default three-cycle sequence.
module pmr_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic mem_rd_o,
    input logic rf_we_o,
    input logic z_we_o
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !mem_rd_o && !rf_we_o && !z_we_o));

    a_r2_read_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (mem_rd_o && busy_o));

    a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    a_r5_zwe_with_rfwe: assert property (@(posedge clk) disable iff (!rst_n)
        z_we_o |-> rf_we_o);

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !rf_we_o);

    a_r7_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(mem_rd_o, 2));

    a_r8_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !busy_o);

    a_r9_no_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rf_we_o) |=> !mem_rd_o);
endmodule

bind pmem_byte_reader pmr_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .mem_rd_o (mem_rd_o),
    .rf_we_o  (rf_we_o),
    .z_we_o   (z_we_o)
);

// File: tb/pmem_byte_reader_tb_top.sv
module pmem_byte_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] z_i = '0;
    logic [4:0]  dst_i = '0;
    logic        post_inc_i = 1'b0;
    logic        imp_r0_i = 1'b0;
    logic        mem_rd_o;
    logic [14:0] mem_addr_o;
    logic [15:0] mem_rdata_i = '0;
    logic        busy_o, rf_we_o, z_we_o;
    logic [4:0]  rf_idx_o;
    logic [7:0]  rf_data_o;
    logic [15:0] z_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pmem_byte_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .z_i(z_i), .dst_i(dst_i),
        .post_inc_i(post_inc_i), .imp_r0_i(imp_r0_i), .mem_rd_o(mem_rd_o),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
        .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
        .z_we_o(z_we_o), .z_o(z_o)
    );

    // Arithmetic memory contents; word 0x1234 is planted as 0x5876.
    function automatic logic [15:0] mem_word(input logic [14:0] wa);
        if (wa == 15'h1234) return 16'h5876;
        return {wa[7:0] ^ 8'hA5, wa[7:0] + wa[14:8] + 8'h3C};
    endfunction

    // Synchronous word memory, one cycle of latency.
    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem_word(mem_addr_o);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation, with disturbing starts in the wait and strobe cycles.
    task automatic run_op(input logic [15:0] z, input logic [4:0] d,
                          input logic pi, input logic imp);
        logic [15:0] w;
        logic [7:0]  eb;
        w  = mem_word(z[15:1]);
        eb = z[0] ? w[15:8] : w[7:0];
        @(negedge clk);
        start_i = 1'b1; z_i = z; dst_i = d; post_inc_i = pi; imp_r0_i = imp;
        @(negedge clk);                                   // read cycle
        start_i = 1'b0; z_i = ~z; dst_i = ~d; post_inc_i = ~pi; imp_r0_i = ~imp; // R10
        check("R2 read", {31'd0, mem_rd_o}, 32'd1);
        check("R2 addr", {17'd0, mem_addr_o}, {17'd0, z[15:1]});
        check("R8 busy", {31'd0, busy_o}, 32'd1);
        @(negedge clk);                                   // wait cycle
        check("R7 early", {31'd0, rf_we_o}, 32'd0);
        check("R8 busy", {31'd0, busy_o}, 32'd1);
        start_i = 1'b1;                                   // R9
        @(negedge clk);                                   // strobe cycle
        check("R7 strobe", {31'd0, rf_we_o}, 32'd1);
        check("R8 busy", {31'd0, busy_o}, 32'd1);
        check("R3 byte R10", {24'd0, rf_data_o}, {24'd0, eb});
        check("R4 idx", {27'd0, rf_idx_o}, imp ? 32'd0 : {27'd0, d});
        check("R5 zwe", {31'd0, z_we_o}, {31'd0, pi});
        if (pi) check("R5 R6 z", {16'd0, z_o}, {16'd0, z + 16'd1});
        @(negedge clk);                                   // idle again
        start_i = 1'b0;
        check("R8 idle", {31'd0, busy_o}, 32'd0);
        check("R9 no read", {31'd0, mem_rd_o}, 32'd0);
        check("R9 no strobe", {31'd0, rf_we_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 rd", {31'd0, mem_rd_o}, 32'd0);
        check("R1 we", {31'd0, rf_we_o}, 32'd0);
        check("R1 zwe", {31'd0, z_we_o}, 32'd0);
        rst_n = 1'b1;
        // R3 planted word 0x5876: even then odd with post-increment.
        run_op(16'h2468, 5'd16, 1'b1, 1'b0);
        run_op(16'h2469, 5'd17, 1'b0, 1'b0);
        // R6 wrap.
        run_op(16'hFFFF, 5'd3, 1'b1, 1'b0);
        run_op(16'hFFFE, 5'd31, 1'b1, 1'b1);
        // Near-exhaustive sweep over low addresses and all modes (R4 R5).
        for (int a = 0; a < 512; a++) begin
            run_op(16'(a * 37), 5'(a), a[0] ^ a[3], a[1] & a[2]);
        end
        for (int d = 0; d < 32; d++) begin
            run_op(16'(16'hC000 + d), 5'(d), 1'b0, 1'b0);
            run_op(16'(16'hC000 + d), 5'(d), 1'b1, 1'b1);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule